// File: doc/BRIEF.md
# Double-Buffered SPI Transmit Path

This block is the transmit half of an SPI controller. Software writes a right-justified word into a 32-bit data register. Only the low 16 bits are kept. The word goes straight into the shift engine when the engine is idle. When the engine is busy, the word waits in a single holding buffer. Reading the register always returns the most recent word written, not the word currently being shifted.

The character length comes from one of four length fields, chosen by a 2-bit format selector. The selector is sampled when a word enters the shift engine. The low N bits of the word are sent on `mosi`, highest of those bits first. The serial clock rests low, and data changes only on its falling edge. Each half period of the serial clock lasts prescaler+1 system cycles.

A module-enable input gates every write. Dropping the enable clears the stored data and the flags, and it abandons any character in flight.

Top module: `spi_tx_path`

## Requirements
- R1: `rd_data` equals zero in bits 31..16, and bits 15..0 hold the last word accepted. Bits 31..16 of `wr_data` are ignored.
- R2: An enabled write while the shifter is idle and the buffer is empty starts a character on the next cycle (`busy`=1). `buf_full` stays 0.
- R3: An enabled write while `busy`=1 parks the word in the buffer and sets `buf_full`. The character in flight is not disturbed.
- R4: When a character ends with `buf_full`=1, `busy` is low for exactly one cycle. The parked word then starts, and `buf_full` clears.
- R5: An enabled write while `busy`=1 and `buf_full`=1 replaces the parked word with the new one and sets `overrun`. `overrun` stays set while the module is enabled.
- R6: While `mod_en`=0, writes have no effect on `rd_data`, `busy` or the output pins.
- R7: One cycle after `mod_en` is sampled at 0, the following all read 0: `rd_data`, `busy`, `buf_full`, `overrun`, `sclk` and `mosi`.
- R8: Length field k sits at `fmt_len[5k+4:5k]`. The field is taken from `fmt_sel` when the character is loaded. Values below 2 act as 2, and values above 16 act as 16. Bit N-1 of the word is sent first, down to bit 0.
- R9: `sclk` starts each character low. It stays low for P+1 cycles, then high for P+1 cycles, for each bit, where P is `prescale` latched at load. `mosi` changes only on falling edges, and `busy` lasts 2·N·(P+1) cycles.
- R10: While idle and after reset, `sclk`=0 and `mosi`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_en | input | 1 | Module enable; 0 clears data and flags |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 32 | Write data, word right-justified in bits 15..0 |
| rd_data | output | 32 | Read-back of the last word written |
| fmt_sel | input | 2 | Selects one of four length fields |
| fmt_len | input | 20 | Four 5-bit character length fields |
| prescale | input | 8 | Serial clock divider; half period is value+1 cycles |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| busy | output | 1 | A character is being shifted |
| buf_full | output | 1 | A word is parked in the buffer |
| overrun | output | 1 | Sticky flag: a parked word was overwritten |

## Verification
The bench builds the block with its default parameters: a 16-bit data field, 5-bit length fields, an 8-bit prescaler and four formats. It programs the four length fields to 8, 16, 2 and 1, and it drives prescaler values 0, 1 and 2. Together these reach the full-width character, the shortest character, the clamp from 1 up to 2, and the fastest divider where the serial clock toggles every cycle. The default widths also allow back-to-back characters that change format between the running word and the parked one.

// File: rtl/spi_tx_path.sv
module spi_tx_path #(
  parameter int BUS_W  = 32,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5,
  parameter int PRE_W  = 8,
  parameter int NFMT   = 4,
  localparam int SEL_W = $clog2(NFMT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mod_en,
  input  logic                  wr_en,
  input  logic [BUS_W-1:0]      wr_data,
  output logic [BUS_W-1:0]      rd_data,
  input  logic [SEL_W-1:0]      fmt_sel,
  input  logic [NFMT*LEN_W-1:0] fmt_len,
  input  logic [PRE_W-1:0]      prescale,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  busy,
  output logic                  buf_full,
  output logic                  overrun
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] hold_q, sh_q;
  logic [BIT_W-1:0]  idx_q;
  logic [PRE_W-1:0]  div_q, pre_q;
  logic              busy_q, full_q, ovr_q, sclk_q;

  logic [LEN_W-1:0]  raw_len, ld_len;
  logic [BIT_W-1:0]  ld_idx;
  logic [DATA_W-1:0] ld_word;
  logic              wr_ok, pull, direct, load;
  logic              unused_hi;

  assign unused_hi = ^wr_data[BUS_W-1:DATA_W];

  assign raw_len = fmt_len[int'(fmt_sel)*LEN_W +: LEN_W];
  assign ld_len  = (raw_len < LEN_W'(2))      ? LEN_W'(2) :
                   (raw_len > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : raw_len;
  assign ld_idx  = BIT_W'(ld_len - LEN_W'(1));

  assign wr_ok   = mod_en & wr_en;
  assign pull    = ~busy_q & full_q;
  assign direct  = wr_ok & ~busy_q & ~full_q;
  assign load    = pull | direct;
  assign ld_word = pull ? hold_q : wr_data[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || !mod_en) begin
      hold_q <= '0;
      sh_q   <= '0;
      idx_q  <= '0;
      div_q  <= '0;
      pre_q  <= '0;
      busy_q <= 1'b0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      if (wr_ok) hold_q <= wr_data[DATA_W-1:0];

      if (wr_ok && (busy_q || full_q)) full_q <= 1'b1;
      else if (pull)                   full_q <= 1'b0;

      if (wr_ok && busy_q && full_q) ovr_q <= 1'b1;

      if (load) begin
        sh_q   <= ld_word;
        idx_q  <= ld_idx;
        div_q  <= '0;
        pre_q  <= prescale;
        sclk_q <= 1'b0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (div_q == pre_q) begin
          div_q  <= '0;
          sclk_q <= ~sclk_q;
          if (sclk_q) begin
            if (idx_q == '0) busy_q <= 1'b0;
            else             idx_q  <= idx_q - BIT_W'(1);
          end
        end else begin
          div_q <= div_q + PRE_W'(1);
        end
      end
    end
  end

  assign rd_data  = {{(BUS_W-DATA_W){1'b0}}, hold_q};
  assign sclk     = sclk_q;
  assign mosi     = busy_q & sh_q[idx_q];
  assign busy     = busy_q;
  assign buf_full = full_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/spi_tx_path_chk.sv
module spi_tx_path_chk #(
  parameter int BUS_W  = 32,
  parameter int DATA_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mod_en,
  input logic             wr_en,
  input logic [BUS_W-1:0] rd_data,
  input logic             sclk,
  input logic             mosi,
  input logic             busy,
  input logic             buf_full,
  input logic             overrun
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BUS_W-1:DATA_W] == '0);

  assert_direct_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && wr_en && !busy && !buf_full) |=> (busy && !buf_full));

  assert_park_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && wr_en && busy) |=> buf_full);

  assert_pull_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && buf_full && !busy) |=> busy);

  assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && overrun) |=> overrun);

  assert_disable_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (rd_data == '0 && !busy && !buf_full && !overrun));

  assert_mosi_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(sclk)) |-> $stable(mosi));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !mosi));
endmodule

bind spi_tx_path spi_tx_path_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .wr_en(wr_en), .rd_data(rd_data),
  .sclk(sclk), .mosi(mosi), .busy(busy), .buf_full(buf_full), .overrun(overrun)
);

// File: tb/spi_tx_path_bench.sv
module spi_tx_path_bench;
  logic        clk = 1'b0, rst_n = 1'b0, mod_en = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  fmt_sel = '0;
  logic [19:0] fmt_len = {5'd1, 5'd2, 5'd16, 5'd8};
  logic [7:0]  prescale = 8'd1;
  logic [31:0] rd_data;
  logic        sclk, mosi, busy, buf_full, overrun;

  spi_tx_path u_spi_tx_path (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .fmt_sel(fmt_sel), .fmt_len(fmt_len), .prescale(prescale),
    .sclk(sclk), .mosi(mosi), .busy(busy), .buf_full(buf_full), .overrun(overrun)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_hold, m_ovr, m_busy, m_cnt, m_len, m_pre, m_word;
  int pend[$];

  function automatic int flen(int sel);
    int raw = int'((fmt_len >> (5 * sel)) & 20'h1f);
    if (raw < 2) return 2;
    if (raw > 16) return 16;
    return raw;
  endfunction

  task automatic m_start(int w);
    m_word = w; m_busy = 1; m_cnt = 0;
    m_len = flen(int'(fmt_sel)); m_pre = int'(prescale);
  endtask

  always @(posedge clk) begin : model
    int ob, on;
    if (!rst_n || !mod_en) begin
      m_hold = 0; m_ovr = 0; m_busy = 0; m_cnt = 0; m_word = 0;
      pend.delete();
    end else begin
      ob = m_busy; on = pend.size();
      if (ob != 0) begin
        m_cnt++;
        if (m_cnt == 2 * m_len * (m_pre + 1)) m_busy = 0;
      end else if (on != 0) begin
        m_start(pend.pop_front());
      end
      if (wr_en) begin
        m_hold = int'(wr_data[15:0]);
        if (ob == 0 && on == 0) m_start(m_hold);
        else begin
          if (ob != 0 && on != 0) m_ovr = 1;
          pend.delete();
          pend.push_back(m_hold);
        end
      end
    end
  end

  always @(negedge clk) begin : compare
    int h, es, em;
    if (rst_n && !done) begin
      es = 0; em = 0;
      if (m_busy != 0) begin
        h  = m_cnt / (m_pre + 1);
        es = h % 2;
        em = (m_word >> (m_len - 1 - h / 2)) & 1;
      end
      chk("R1 rd_data", int'(rd_data), m_hold);
      chk("R2 busy", int'(busy), m_busy);
      chk("R3 buf_full", int'(buf_full), int'(pend.size() != 0));
      chk("R5 overrun", int'(overrun), m_ovr);
      chk("R9 sclk", int'(sclk), es);
      chk("R8 mosi", int'(mosi), em);
    end
  end

  task automatic wr(logic [31:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && (busy || buf_full); i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R10 reset sclk", int'(sclk), 0);
    chk("R10 reset mosi", int'(mosi), 0);
    chk("R1 reset rd_data", int'(rd_data), 0);
    rst_n = 1'b1;

    // R6: write while disabled is dropped
    wr(32'h0000_1111);
    @(negedge clk);
    chk("R6 rd_data after disabled write", int'(rd_data), 0);
    chk("R6 busy after disabled write", int'(busy), 0);
    mod_en = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R5 R4 with 8-bit format, prescale 1
    wr(32'hFFFF_00A5);
    chk("R1 readback masks upper", int'(rd_data), 32'h00A5);
    chk("R2 direct load busy", int'(busy), 1);
    chk("R2 direct load buffer empty", int'(buf_full), 0);
    chk("R8 first bit is bit7", int'(mosi), 1);
    wr(32'h0000_003C);
    chk("R3 parked", int'(buf_full), 1);
    wr(32'h0000_00C3);
    chk("R5 overrun set", int'(overrun), 1);
    chk("R5 newest readback", int'(rd_data), 32'h00C3);
    while (busy) @(negedge clk);
    chk("R4 gap keeps buffer", int'(buf_full), 1);
    @(negedge clk);
    chk("R4 parked word started", int'(busy), 1);
    chk("R4 buffer cleared", int'(buf_full), 0);
    wait_idle();

    // R9 full-width character, prescale 2
    prescale = 8'd2; fmt_sel = 2'd1;
    wr(32'h0000_8001);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R9 busy length 16 bits P=2", n, 96);

    // R7 abort mid-character
    fmt_sel = 2'd0; prescale = 8'd1;
    wr(32'h0000_0077);
    wr(32'h0000_0011);
    repeat (3) @(negedge clk);
    mod_en = 1'b0;
    @(negedge clk);
    chk("R7 busy cleared", int'(busy), 0);
    chk("R7 buffer cleared", int'(buf_full), 0);
    chk("R7 overrun cleared", int'(overrun), 0);
    chk("R7 data cleared", int'(rd_data), 0);
    chk("R7 sclk low", int'(sclk), 0);
    mod_en = 1'b1;
    @(negedge clk);

    // R8 short lengths, prescale 0
    prescale = 8'd0; fmt_sel = 2'd2;
    wr(32'h0000_FFFE);
    chk("R8 2-bit first bit", int'(mosi), 1);
    wait_idle();
    fmt_sel = 2'd3;
    wr(32'h0000_0001);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R8 clamp 1 to 2 bits", n, 4);

    // back-to-back with a format change for the parked word
    prescale = 8'd1; fmt_sel = 2'd0;
    wr(32'h0000_1234);
    fmt_sel = 2'd1;
    wr(32'h0000_ABCD);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R10 idle sclk", int'(sclk), 0);
    chk("R10 idle mosi", int'(mosi), 0);
    finish_run();
  end
endmodule